// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a four-output PWM generator and the output pads. It watches two comparator trip inputs and an active-low external interrupt pin. When a fault source chosen by a 3-bit selector becomes active, or software raises the shutdown flag, all four outputs are forced into programmable safe states. The forcing is combinational, so it does not wait for a clock edge.

Outputs A and C form one pair and B and D the other. Each pair has a 2-bit safe-state code: drive high, drive low, or release the pin (high-impedance, modelled as output enable low). A sticky flag records the shutdown. Software clears it, or an optional auto-restart clears it at the start of a PWM period once every selected source is quiet. Configuration goes through a two-address write/read port.

Top module: `pwm_fault_guard`

## Requirements
- R1: After synchronous reset, the control register (address 0) and the status register (address 1) both read 0x00, and every output is enabled and follows its PWM drive bit.
- R2: Control bits [2:0] select the fault sources. Bit 0 enables comparator 1, bit 1 enables comparator 2 and bit 2 enables the interrupt pin, so 000 disables all three and 111 enables all of them. An active selected source sets the flag at the next clock edge. An unselected source has no effect.
- R3: The interrupt pin is active low. A 0 on it is a fault, and a 1 is not.
- R4: Writing 1 to status bit 0 sets the flag and forces the outputs into their safe states.
- R5: While the flag is 0 and no selected source is active, output n is enabled and carries PWM drive bit n, for any drive pattern.
- R6: Outputs 0 and 2 (A, C) use the safe code in control bits [4:3]. Outputs 1 and 3 (B, D) use the code in bits [6:5]. If the upper code bit is 1, the output enable is 0 and the data is 0. If it is 0, the output is enabled and carries the lower code bit.
- R7: A selected fault forces the safe states in the same cycle, before any clock edge.
- R8: Without auto-restart, the flag stays set after the fault goes away, including across period-start pulses. The outputs stay in the safe state.
- R9: Writing 0 to status bit 0 clears the flag when no selected source is active. The write is ignored while one is active.
- R10: With control bit 7 set, the flag clears at the first clock edge where period_start is high and no selected source is active. It does not clear before that edge.
- R11: Reading address 0 returns the control value last written, and reading address 1 returns the flag in bit 0 with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cmp1_trip | input | 1 | Comparator 1 fault, active high |
| cmp2_trip | input | 1 | Comparator 2 fault, active high |
| ext_int_n | input | 1 | External interrupt pin, fault when low |
| period_start | input | 1 | Pulse at the start of each PWM period |
| pwm_drv | input | 4 | PWM drive for outputs A, B, C, D (bits 0 to 3) |
| pin_data | output | 4 | Output data per pin |
| pin_oe | output | 4 | Output enable per pin (0 means high-impedance) |

## Verification
The hardest condition to reach is the race between clearing and a fault that is still present. Examples are a software clear, or a period-start pulse under auto-restart, arriving while a selected source is held active. In those cases the flag must survive. The stimulus holds a comparator high across the clear write, and across a period-start pulse, before releasing it. It then checks that the flag clears only on the following period start. The async path is checked by sampling the enables one nanosecond after the fault input moves, well before the next edge.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_OUT   = 4;
    localparam int SRC_W     = 3;
    localparam int SAFE_W    = 2;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 3'b000,
        SRC_C1     = 3'b001,
        SRC_C2     = 3'b010,
        SRC_C12    = 3'b011,
        SRC_INT    = 3'b100,
        SRC_INT_C1 = 3'b101,
        SRC_INT_C2 = 3'b110,
        SRC_ALL    = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic              restart_en;
        logic [SAFE_W-1:0] safe_bd;
        logic [SAFE_W-1:0] safe_ac;
        src_sel_e          src;
    } ctrl_t;

    typedef struct packed {
        logic data;
        logic en;
    } pin_t;

    function automatic pin_t safe_pin(input logic [SAFE_W-1:0] code);
        pin_t p;
        if (code[1]) begin
            p.data = 1'b0;
            p.en   = 1'b0;
        end else begin
            p.data = code[0];
            p.en   = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/pfg_src_sel.sv
module pfg_src_sel
    import pfg_pkg::*;
(
    input  src_sel_e sel,
    input  logic     cmp1_trip,
    input  logic     cmp2_trip,
    input  logic     ext_int_n,
    output logic     fault
);
    logic [SRC_W-1:0] raw;

    always_comb begin
        raw[0] = cmp1_trip;
        raw[1] = cmp2_trip;
        raw[2] = ~ext_int_n;
        fault  = |(raw & sel);
    end
endmodule

// File: rtl/pfg_status.sv
module pfg_status (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic restart_en,
    input  logic period_start,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (fault || sw_set)
            flag <= 1'b1;
        else if (flag && sw_clr)
            flag <= 1'b0;
        else if (flag && restart_en && period_start)
            flag <= 1'b0;
    end

    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (rst)
        fault |=> flag); // R2
    AST_SW_SET: assert property (@(posedge clk) disable iff (rst)
        sw_set |=> flag); // R4
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (flag && sw_clr && fault) |=> flag); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !sw_clr && !(restart_en && period_start)) |=> flag); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (flag && restart_en && period_start && !fault && !sw_set) |=> !flag); // R10
endmodule

// File: rtl/pfg_out_stage.sv
module pfg_out_stage
    import pfg_pkg::*;
#(
    parameter int N = NUM_OUT
) (
    input  logic              shut,
    input  logic [SAFE_W-1:0] safe_ac,
    input  logic [SAFE_W-1:0] safe_bd,
    input  logic [N-1:0]      pwm_drv,
    output logic [N-1:0]      pin_data,
    output logic [N-1:0]      pin_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_t p;
        always_comb begin
            if (shut)
                p = safe_pin((i % 2 == 0) ? safe_ac : safe_bd);
            else begin
                p.data = pwm_drv[i];
                p.en   = 1'b1;
            end
            pin_data[i] = p.data;
            pin_oe[i]   = p.en;
        end
    end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               cmp1_trip,
    input  logic               cmp2_trip,
    input  logic               ext_int_n,
    input  logic               period_start,
    input  logic [NUM_OUT-1:0] pwm_drv,
    output logic [NUM_OUT-1:0] pin_data,
    output logic [NUM_OUT-1:0] pin_oe
);
    ctrl_t ctrl_q;
    logic  fault;
    logic  flag;
    logic  sw_set;
    logic  sw_clr;
    logic  stat_wr;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (reg_we && reg_addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(reg_wdata);
    end

    always_comb begin
        stat_wr   = reg_we && (reg_addr == ADDR_STAT);
        sw_set    = stat_wr && reg_wdata[0];
        sw_clr    = stat_wr && !reg_wdata[0];
        reg_rdata = (reg_addr == ADDR_CTRL) ? REG_W'(ctrl_q)
                                            : {{(REG_W-1){1'b0}}, flag};
    end

    pfg_src_sel u_src (
        .sel       (ctrl_q.src),
        .cmp1_trip (cmp1_trip),
        .cmp2_trip (cmp2_trip),
        .ext_int_n (ext_int_n),
        .fault     (fault)
    );

    pfg_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .fault        (fault),
        .sw_set       (sw_set),
        .sw_clr       (sw_clr),
        .restart_en   (ctrl_q.restart_en),
        .period_start (period_start),
        .flag         (flag)
    );

    pfg_out_stage #(.N(NUM_OUT)) u_out (
        .shut     (flag | fault),
        .safe_ac  (ctrl_q.safe_ac),
        .safe_bd  (ctrl_q.safe_bd),
        .pwm_drv  (pwm_drv),
        .pin_data (pin_data),
        .pin_oe   (pin_oe)
    );

    AST_PASS_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (!flag && !fault) |-> (pin_oe == '1 && pin_data == pwm_drv)); // R5
    AST_AC_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl_q.safe_ac[1]) |-> (!pin_oe[0] && !pin_oe[2])); // R6
    AST_BD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl_q.safe_bd[1]) |-> (!pin_oe[1] && !pin_oe[3])); // R6
endmodule

// File: tb/pwm_fault_guard_test.sv
module pwm_fault_guard_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       cmp1_trip, cmp2_trip, ext_int_n, period_start;
    logic [3:0] pwm_drv, pin_data, pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwm_fault_guard uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp1_trip(cmp1_trip), .cmp2_trip(cmp2_trip), .ext_int_n(ext_int_n),
        .period_start(period_start), .pwm_drv(pwm_drv),
        .pin_data(pin_data), .pin_oe(pin_oe)
    );

    // {sel[2:0], cmp1, cmp2, int_n, expected_fault}
    localparam logic [6:0] VEC [12] = '{
        {3'b000, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'b001, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'b001, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b010, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b011, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'b100, 1'b0, 1'b0, 1'b0, 1'b1},
        {3'b100, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'b101, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'b110, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b110, 1'b0, 1'b0, 1'b0, 1'b1},
        {3'b111, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle_faults();
        cmp1_trip = 1'b0; cmp2_trip = 1'b0; ext_int_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        period_start = 1'b0; pwm_drv = 4'b0110;
        idle_faults();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, d); check("R1 ctrl", d, 8'h00);
        rd(1'b1, d); check("R1 status", d, 8'h00);
        check("R1 oe", {4'h0, pin_oe}, 8'h0F);
        check("R1 data", {4'h0, pin_data}, 8'h06);

        // R5 pass-through patterns
        pwm_drv = 4'b1010; #1 check("R5 data 1010", {4'h0, pin_data}, 8'h0A);
        pwm_drv = 4'b0101; #1 check("R5 data 0101", {4'h0, pin_data}, 8'h05);

        // R2 R3 R7 table walk, AC released when shut
        foreach (VEC[i]) begin
            idle_faults();
            wr(1'b0, {3'b000, 2'b10, VEC[i][6:4]});
            wr(1'b1, 8'h00);
            @(negedge clk);
            cmp1_trip = VEC[i][3]; cmp2_trip = VEC[i][2]; ext_int_n = VEC[i][1];
            #1 check($sformatf("R7 R2 R3 async vec%0d", i), {7'h0, pin_oe[0]}, {7'h0, !VEC[i][0]});
            @(negedge clk);
            idle_faults();
            rd(1'b1, d); check($sformatf("R2 R8 latch vec%0d", i), d, {7'h0, VEC[i][0]});
            wr(1'b1, 8'h00);
        end

        // R4 R6 R11 drive-level safe states: AC=01 (high), BD=00 (low)
        pwm_drv = 4'b1010;
        wr(1'b0, 8'b0_00_01_000);
        rd(1'b0, d); check("R11 ctrl readback", d, 8'h08);
        wr(1'b1, 8'h01);
        check("R4 R6 data drive", {4'h0, pin_data}, 8'h05);
        check("R6 oe drive", {4'h0, pin_oe}, 8'h0F);
        rd(1'b1, d); check("R11 status readback", d, 8'h01);
        // AC=00 low, BD=11 released
        wr(1'b0, 8'b0_11_00_000);
        check("R6 oe BD released", {4'h0, pin_oe}, 8'h05);
        check("R6 data BD released", {4'h0, pin_data}, 8'h00);
        wr(1'b1, 8'h00);
        check("R9 clear resumes", {4'h0, pin_data}, 8'h0A);

        // R9 clear ignored while fault active
        wr(1'b0, 8'b0_10_10_001);
        @(negedge clk); cmp1_trip = 1'b1;
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R9 clear ignored", d, 8'h01);
        idle_faults();
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R9 clear accepted", d, 8'h00);

        // R8 sticky across period start without restart
        @(negedge clk); cmp1_trip = 1'b1;
        @(negedge clk); idle_faults(); period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
        rd(1'b1, d); check("R8 sticky", d, 8'h01);
        check("R8 outputs held", {4'h0, pin_oe}, 8'h00);
        wr(1'b1, 8'h00);

        // R10 auto-restart
        wr(1'b0, 8'b1_10_10_001);
        @(negedge clk); cmp1_trip = 1'b1; period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
        rd(1'b1, d); check("R10 no clear in fault", d, 8'h01);
        idle_faults();
        @(negedge clk);
        rd(1'b1, d); check("R10 waits period", d, 8'h01);
        check("R10 outputs held", {4'h0, pin_oe}, 8'h00);
        period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
        rd(1'b1, d); check("R10 cleared", d, 8'h00);
        check("R10 resumed", {4'h0, pin_data}, 8'h0A);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule